// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bit Array

This block models one parallel I/O port of a small controller. The port has no direction register. Each pin has one output latch bit. A latch bit of 0 pulls its pin low. A latch bit of 1 lets go of the pin, which then serves as an input. Software can read the port in two ways. The latch read returns the stored bits. The pin read returns the levels actually present on the pins, after they pass a two-flop synchronizer. Read-modify-write updates take their operand from the latch read, so a pin held low from outside cannot corrupt a bit that software did not mean to change.

A parameter chooses one of four variants:

- **Weak-pull-up:** a released pin is pulled high weakly.
- **Open-drain:** a released pin gets no pull-up and floats.
- **Alternate-function:** a released pin follows a peripheral output signal.
- **Upper-address:** the pins can be taken over by an external memory bus.

The open-drain variant can also be taken over by the external memory bus. The outputs are a drive-low enable and a pull-up enable for each pin. They are registered and control the pad logic outside the block.

Top module: `qport_array`

## Requirements
- R1: While reset is active, the latch is set to all ones and every drive-low enable is 0. The first value read back after reset is all ones. The pull-up enables reset to all ones in every variant except open-drain, where they reset to 0.
- R2: A write (wr_en=1) loads wr_data into the latch. After the next rising edge, latch_q shows the new value. Outside a bus override and with no alternate function, each drive_low bit becomes the inverse of its latch bit at that same edge.
- R3: In the weak-pull-up, alternate-function and upper-address variants, pull_up is 1 on every released pin. A pin pulled low from outside reads 0 through pin_q.
- R4: In the open-drain variant, pull_up stays 0 whenever no bus override is active. A released pin reads whatever level the outside world puts on it.
- R5: When rmw_en=1 and wr_en=0, the latch takes a new value computed from its own current contents and rmw_arg, not from the pin levels. The rmw_op codes are:
  - 0: AND
  - 1: OR
  - 2: XOR
  - 3: clear the masked bits (latch AND NOT rmw_arg)
- R6: If wr_en and rmw_en are both 1 in the same cycle, the write wins and the latch takes wr_data.
- R7: pin_q reports the pin levels through two flops. A level that is present before rising edge k appears on pin_q after edge k+1, and not after edge k.
- R8: In the alternate-function variant, each pin's effective output is its latch bit AND its alt_out bit. drive_low is the inverse of that value, and pull_up equals it, one edge after the inputs change.
- R9: In the open-drain and upper-address variants, bus_en=1 makes the pins follow bus_val from the next edge: drive_low = NOT bus_val and pull_up = bus_val. The latch is left unchanged by the override, although writes during the override still land. When bus_en falls, the pins return to the latch value.
- R10: In the weak-pull-up and alternate-function variants, bus_en and bus_val have no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load the latch from wr_data |
| wr_data | input | WIDTH | Value to load into the latch |
| rmw_en | input | 1 | Apply a read-modify-write operation to the latch |
| rmw_op | input | 2 | Operation code: 0 AND, 1 OR, 2 XOR, 3 clear-mask |
| rmw_arg | input | WIDTH | Operand for the read-modify-write operation |
| alt_out | input | WIDTH | Peripheral output signal for each pin (alternate-function variant) |
| bus_en | input | 1 | External bus override active |
| bus_val | input | WIDTH | Address or data value driven during the override |
| pin_in | input | WIDTH | Resolved pin levels seen from the pads |
| latch_q | output | WIDTH | Latch read path |
| pin_q | output | WIDTH | Synchronized pin read path |
| drive_low | output | WIDTH | Pull-down enable for each pin |
| pull_up | output | WIDTH | Pull-up or drive-high enable for each pin |

## Verification
The bench builds four copies of the block. All use WIDTH=8, and each uses a different variant. The copies share the control inputs, so a single write sequence can be compared across them:

- The pull-up behaviour of the open-drain copy is checked against the weak-pull-up copy.
- The bus override of the upper-address copy is checked against the weak-pull-up copy, which must ignore it.

The pins are modelled as a resolved wire. On that wire, a drive-low beats an external source, an external source beats a pull-up, and a pin with nothing on it reads 0. This model lets the bench show the difference between the latch read and the pin read, and that read-modify-write operations start from the latch.

// File: rtl/qp_pkg.sv
package qp_pkg;

  typedef enum logic [1:0] {
    KIND_WEAK   = 2'd0,
    KIND_OPEN   = 2'd1,
    KIND_ALT    = 2'd2,
    KIND_UPADDR = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    OP_AND   = 2'd0,
    OP_OR    = 2'd1,
    OP_XOR   = 2'd2,
    OP_CLEAR = 2'd3
  } rmw_op_e;

endpackage

// File: rtl/qp_latch.sv
module qp_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rmw_en,
  input  logic [1:0]       rmw_op,
  input  logic [WIDTH-1:0] rmw_arg,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] latch_nxt
);
  import qp_pkg::*;

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] rmw_res;

  always_comb begin
    unique case (rmw_op_e'(rmw_op))
      OP_AND:   rmw_res = latch_q & rmw_arg;
      OP_OR:    rmw_res = latch_q | rmw_arg;
      OP_XOR:   rmw_res = latch_q ^ rmw_arg;
      default:  rmw_res = latch_q & ~rmw_arg;
    endcase
  end

  always_comb begin
    if (rst)         latch_nxt = ALL_ONES;
    else if (wr_en)  latch_nxt = wr_data;
    else if (rmw_en) latch_nxt = rmw_res;
    else             latch_nxt = latch_q;
  end

  always_ff @(posedge clk) begin
    latch_q <= latch_nxt;
  end

  p_reset_ones_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> latch_q == ALL_ONES);

  p_write_load_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> latch_q == $past(wr_data));

  p_rmw_or_from_latch_r5: assert property (@(posedge clk) disable iff (rst)
    (rmw_en && !wr_en && rmw_op == 2'd1) |=> latch_q == ($past(latch_q) | $past(rmw_arg)));

  p_rmw_clear_from_latch_r5: assert property (@(posedge clk) disable iff (rst)
    (rmw_en && !wr_en && rmw_op == 2'd3) |=> latch_q == ($past(latch_q) & ~$past(rmw_arg)));

  p_write_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rmw_en) |=> latch_q == $past(wr_data));

endmodule

// File: rtl/qp_sync.sv
module qp_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];

  if (STAGES == 2) begin : g_chk2
    p_two_flop_delay_r7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2)) |-> q == $past(d, 2));
  end

endmodule

// File: rtl/qp_drive.sv
module qp_drive #(
  parameter int            WIDTH = 8,
  parameter qp_pkg::kind_e KIND  = qp_pkg::KIND_WEAK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] latch_nxt,
  input  logic [WIDTH-1:0] alt_out,
  input  logic             bus_en,
  input  logic [WIDTH-1:0] bus_val,
  output logic [WIDTH-1:0] drive_low,
  output logic [WIDTH-1:0] pull_up
);
  import qp_pkg::*;

  localparam bit               HAS_BUS = (KIND == KIND_OPEN) || (KIND == KIND_UPADDR);
  localparam logic [WIDTH-1:0] PU_RST  = (KIND == KIND_OPEN) ? '0 : {WIDTH{1'b1}};

  logic [WIDTH-1:0] eff;
  logic [WIDTH-1:0] pu_d;

  if (KIND == KIND_ALT) begin : g_alt
    logic unused_bus;
    assign unused_bus = bus_en ^ (^bus_val);
    assign eff  = latch_nxt & alt_out;
    assign pu_d = eff;
  end else if (KIND == KIND_OPEN) begin : g_open
    logic unused_alt;
    assign unused_alt = ^alt_out;
    assign eff  = bus_en ? bus_val : latch_nxt;
    assign pu_d = bus_en ? bus_val : '0;
  end else if (KIND == KIND_UPADDR) begin : g_upaddr
    logic unused_alt;
    assign unused_alt = ^alt_out;
    assign eff  = bus_en ? bus_val : latch_nxt;
    assign pu_d = eff;
  end else begin : g_weak
    logic unused_in;
    assign unused_in = (^alt_out) ^ bus_en ^ (^bus_val);
    assign eff  = latch_nxt;
    assign pu_d = latch_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_low <= '0;
      pull_up   <= PU_RST;
    end else begin
      drive_low <= ~eff;
      pull_up   <= pu_d;
    end
  end

  if (HAS_BUS) begin : g_bus_chk
    p_bus_drive_r9: assert property (@(posedge clk) disable iff (rst)
      bus_en |=> (drive_low == ~$past(bus_val)) && (pull_up == $past(bus_val)));
  end

  if (KIND == KIND_OPEN) begin : g_od_chk
    p_od_no_pullup_r4: assert property (@(posedge clk) disable iff (rst)
      !$past(bus_en) |-> pull_up == '0);
  end

  if (KIND == KIND_ALT) begin : g_alt_chk
    p_alt_and_r8: assert property (@(posedge clk) disable iff (rst)
      (alt_out == '0) |=> pull_up == '0);
  end

endmodule

// File: rtl/qport_array.sv
module qport_array #(
  parameter int            WIDTH = 8,
  parameter qp_pkg::kind_e KIND  = qp_pkg::KIND_WEAK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rmw_en,
  input  logic [1:0]       rmw_op,
  input  logic [WIDTH-1:0] rmw_arg,
  input  logic [WIDTH-1:0] alt_out,
  input  logic             bus_en,
  input  logic [WIDTH-1:0] bus_val,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] pin_q,
  output logic [WIDTH-1:0] drive_low,
  output logic [WIDTH-1:0] pull_up
);
  import qp_pkg::*;

  logic [WIDTH-1:0] latch_nxt;

  qp_latch #(.WIDTH(WIDTH)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rmw_en    (rmw_en),
    .rmw_op    (rmw_op),
    .rmw_arg   (rmw_arg),
    .latch_q   (latch_q),
    .latch_nxt (latch_nxt)
  );

  qp_drive #(.WIDTH(WIDTH), .KIND(KIND)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .latch_nxt (latch_nxt),
    .alt_out   (alt_out),
    .bus_en    (bus_en),
    .bus_val   (bus_val),
    .drive_low (drive_low),
    .pull_up   (pull_up)
  );

  qp_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_q)
  );

  p_bus_keeps_latch_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !wr_en && !rmw_en) |=> $stable(latch_q));

  if (KIND == KIND_WEAK) begin : g_weak_chk
    p_weak_tracks_latch_r2: assert property (@(posedge clk) disable iff (rst)
      drive_low == ~latch_q);
    p_weak_pullup_r3: assert property (@(posedge clk) disable iff (rst)
      pull_up == latch_q);
  end

endmodule

// File: tb/test_qport_array.sv
module test_qport_array;
  import qp_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rmw_en = 1'b0;
  logic [1:0]   rmw_op = 2'd0;
  logic [W-1:0] rmw_arg = '0;
  logic [W-1:0] alt_out = '1;
  logic         bus_en = 1'b0;
  logic [W-1:0] bus_val = '0;
  logic [W-1:0] ext_en = '0;
  logic [W-1:0] ext_val = '0;

  logic [W-1:0] lq_w, pq_w, dl_w, pu_w, pin_w;
  logic [W-1:0] lq_o, pq_o, dl_o, pu_o, pin_o;
  logic [W-1:0] lq_a, pq_a, dl_a, pu_a, pin_a;
  logic [W-1:0] lq_u, pq_u, dl_u, pu_u, pin_u;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // resolved wire: drive-low beats external source beats pull-up; nothing reads 0
  assign pin_w = ~dl_w & ((ext_en & ext_val) | (~ext_en & pu_w));
  assign pin_o = ~dl_o & ((ext_en & ext_val) | (~ext_en & pu_o));
  assign pin_a = ~dl_a & ((ext_en & ext_val) | (~ext_en & pu_a));
  assign pin_u = ~dl_u & ((ext_en & ext_val) | (~ext_en & pu_u));

  qport_array #(.WIDTH(W), .KIND(KIND_WEAK)) i_qport_array (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rmw_en(rmw_en),
    .rmw_op(rmw_op), .rmw_arg(rmw_arg), .alt_out(alt_out), .bus_en(bus_en),
    .bus_val(bus_val), .pin_in(pin_w), .latch_q(lq_w), .pin_q(pq_w),
    .drive_low(dl_w), .pull_up(pu_w));

  qport_array #(.WIDTH(W), .KIND(KIND_OPEN)) i_qport_array_od (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rmw_en(rmw_en),
    .rmw_op(rmw_op), .rmw_arg(rmw_arg), .alt_out(alt_out), .bus_en(bus_en),
    .bus_val(bus_val), .pin_in(pin_o), .latch_q(lq_o), .pin_q(pq_o),
    .drive_low(dl_o), .pull_up(pu_o));

  qport_array #(.WIDTH(W), .KIND(KIND_ALT)) i_qport_array_alt (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rmw_en(rmw_en),
    .rmw_op(rmw_op), .rmw_arg(rmw_arg), .alt_out(alt_out), .bus_en(bus_en),
    .bus_val(bus_val), .pin_in(pin_a), .latch_q(lq_a), .pin_q(pq_a),
    .drive_low(dl_a), .pull_up(pu_a));

  qport_array #(.WIDTH(W), .KIND(KIND_UPADDR)) i_qport_array_up (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rmw_en(rmw_en),
    .rmw_op(rmw_op), .rmw_arg(rmw_arg), .alt_out(alt_out), .bus_en(bus_en),
    .bus_val(bus_val), .pin_in(pin_u), .latch_q(lq_u), .pin_q(pq_u),
    .drive_low(dl_u), .pull_up(pu_u));

  // {write value, externally pulled-low mask, expected pin read}
  localparam logic [23:0] VEC [6] = '{
    {8'h55, 8'h00, 8'h55},
    {8'hAA, 8'h00, 8'hAA},
    {8'hFF, 8'h0F, 8'hF0},
    {8'hF0, 8'h3C, 8'hC0},
    {8'h00, 8'h00, 8'h00},
    {8'h81, 8'h01, 8'h80}
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rmw(input logic [1:0] op, input logic [W-1:0] arg);
    @(negedge clk);
    rmw_en = 1'b1; rmw_op = op; rmw_arg = arg;
    @(negedge clk);
    rmw_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 weak latch", lq_w, 8'hFF);
    chk("R1 weak drive_low", dl_w, 8'h00);
    chk("R1 weak pull_up", pu_w, 8'hFF);
    chk("R1 od pull_up", pu_o, 8'h00);
    chk("R1 od drive_low", dl_o, 8'h00);

    // table walk on weak-pull-up copy (R2, R3)
    for (int i = 0; i < 6; i++) begin
      ext_en = VEC[i][15:8]; ext_val = '0;
      do_write(VEC[i][23:16]);
      chk("R2 latch read", lq_w, VEC[i][23:16]);
      chk("R2 drive_low", dl_w, ~VEC[i][23:16]);
      settle();
      chk("R3 pin read", pq_w, VEC[i][7:0]);
      chk("R3 pull_up", pu_w, VEC[i][23:16]);
    end
    ext_en = '0;

    // R6 write beats rmw
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h3C; rmw_en = 1'b1; rmw_op = 2'd1; rmw_arg = 8'h01;
    @(negedge clk);
    wr_en = 1'b0; rmw_en = 1'b0;
    chk("R6 write priority", lq_w, 8'h3C);

    // R5 rmw from latch with all pins pulled low externally
    do_write(8'hF0);
    ext_en = 8'hFF; ext_val = 8'h00;
    settle();
    chk("R5 pins read low", pq_w, 8'h00);
    do_rmw(2'd2, 8'h0F);
    chk("R5 xor", lq_w, 8'hFF);
    do_rmw(2'd3, 8'h81);
    chk("R5 clear", lq_w, 8'h7E);
    do_rmw(2'd0, 8'h0F);
    chk("R5 and", lq_w, 8'h0E);
    do_rmw(2'd1, 8'h80);
    chk("R5 or", lq_w, 8'h8E);
    ext_en = '0;

    // R7 synchronizer latency
    do_write(8'hFF);
    settle();
    chk("R7 before", pq_w, 8'hFF);
    ext_en = 8'h01; ext_val = 8'h00;
    @(negedge clk);
    chk("R7 one edge", pq_w, 8'hFF);
    @(negedge clk);
    chk("R7 two edges", pq_w, 8'hFE);
    ext_en = '0;

    // R4 open-drain
    do_write(8'h0F);
    ext_en = 8'hFF; ext_val = 8'hA5;
    settle();
    chk("R4 od pin read", pq_o, 8'h05);
    chk("R4 od pull_up", pu_o, 8'h00);
    chk("R4 od drive_low", dl_o, 8'hF0);
    ext_en = '0; ext_val = '0;

    // R8 alternate function
    @(negedge clk);
    alt_out = 8'h5A;
    do_write(8'hFF);
    chk("R8 alt drive_low", dl_a, 8'hA5);
    chk("R8 alt pull_up", pu_a, 8'h5A);
    @(negedge clk);
    alt_out = 8'hFF;
    do_write(8'h0F);
    chk("R8 alt latch zero wins", dl_a, 8'hF0);
    @(negedge clk);
    alt_out = 8'h00;
    @(negedge clk);
    chk("R8 alt off", pu_a, 8'h00);
    alt_out = 8'hFF;

    // R9 / R10 bus override
    do_write(8'h12);
    @(negedge clk);
    bus_en = 1'b1; bus_val = 8'h9A;
    @(negedge clk);
    chk("R9 up drive_low", dl_u, 8'h65);
    chk("R9 up pull_up", pu_u, 8'h9A);
    chk("R9 up latch kept", lq_u, 8'h12);
    chk("R9 od drive_low", dl_o, 8'h65);
    chk("R9 od pull_up", pu_o, 8'h9A);
    chk("R10 weak ignores bus", dl_w, 8'hED);
    chk("R10 alt ignores bus", pu_a, 8'h12);
    do_write(8'h34);
    chk("R9 write during bus", lq_u, 8'h34);
    chk("R9 bus still drives", dl_u, 8'h65);
    @(negedge clk);
    bus_en = 1'b0;
    @(negedge clk);
    chk("R9 up release", dl_u, 8'hCB);
    chk("R9 up release pull_up", pu_u, 8'h34);
    chk("R9 od release", dl_o, 8'hCB);
    chk("R9 od release pull_up", pu_o, 8'h00);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule